// File: doc/BRIEF.md
# Linear Chirp Frequency Sweep Engine

This block produces the tuning and phase words for a frequency-swept direct digital synthesizer. A 48-bit frequency register holds a signed sum of steps. The current output frequency is the programmed start frequency plus that sum. A ramp-rate counter decides how often the signed delta word is added to the sum. A second 48-bit register integrates the current frequency once per clock and gives the phase word. A later lookup stage turns that phase word into a waveform.

The sweep has no end point. The sign of the delta word sets its direction, and it runs until outside control intervenes. There are three such controls:
- `hold_i` freezes the frequency.
- `clr_freq_i` snaps the frequency back to the start value.
- `clr_phase_i` forces the phase word to zero, which silences the output.

An internal update timer can issue the frequency clear itself at a fixed interval. This gives a repeating sawtooth chirp without any outside sequencing. All inputs are plain control and configuration levels sampled on every clock, with no handshake. No output applies back-pressure: the words are valid in every cycle after reset.

Top module: `chirp_sweep_engine`

## Requirements
- R1: While `rst_n` is low and after its release, before any clock edge, `freq_o` equals `start_freq_i` and `phase_o` is zero.
- R2: `freq_o` always equals `start_freq_i` plus the accumulated delta sum, modulo 2^48. A change of `start_freq_i` shows on `freq_o` in the same cycle.
- R3: With ramp value N, the delta is added once every N+1 unheld, uncleared clocks, counted from reset or from the last clear. N=0 adds on every clock. If N is lowered below the count already reached, the step happens on the next unheld clock.
- R4: `delta_i` is two's complement. A value with bit 47 set lowers the frequency by its magnitude on each step.
- R5: While `hold_i` is high and no clear is active, `freq_o` stays constant and the ramp count is frozen. The phase keeps advancing by the held frequency.
- R6: A frequency clear (`clr_freq_i` or an automatic tick) overrides hold. After the next edge the sum is zero, so `freq_o` equals `start_freq_i`, and the ramp count restarts from zero.
- R7: While `clr_phase_i` is high, `phase_o` is zero after each edge. The frequency path is not affected.
- R8: On each edge without a phase clear, `phase_o` gains the `freq_o` value from before the edge, modulo 2^48.
- R9: With `upd_en_i` high and period P, an automatic frequency clear fires every P+1 clocks, counted from the enable or from the last tick. With `upd_en_i` low, no automatic clear happens and the timer resets to zero.
- R10: The frequency keeps stepping past 2^48 and wraps. No destination value stops it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_freq_i | input | 48 | Start frequency word |
| delta_i | input | 48 | Signed step added per ramp interval |
| ramp_rate_i | input | 20 | Ramp interval minus one, in clocks |
| upd_period_i | input | 32 | Automatic clear interval minus one, in clocks |
| upd_en_i | input | 1 | Enables the automatic clear timer |
| hold_i | input | 1 | Freezes the frequency sweep |
| clr_freq_i | input | 1 | Returns the frequency to the start value |
| clr_phase_i | input | 1 | Forces the phase word to zero |
| freq_o | output | 48 | Current frequency word |
| phase_o | output | 48 | Current phase word |

## Verification
A wrong delta sum shows on `freq_o` at the very next sample. It then corrupts `phase_o` from the following edge on and never heals, because the phase integrates it. A ramp or update counter that is off by one stays hidden until its interval ends. At that point `freq_o` steps or resets one clock early or late, so the bench compares both words against a reference model on every cycle. The directed runs use short intervals, so such a miscount shows within a few clocks.

// File: rtl/chirp_pkg.sv
package chirp_pkg;
  localparam int FREQ_W = 48;
  localparam int RATE_W = 20;
  localparam int UPD_W  = 32;
  typedef logic [FREQ_W-1:0] word_t;
endpackage

// File: rtl/chirp_ramp_timer.sv
module chirp_ramp_timer #(
  parameter int RATE_W = chirp_pkg::RATE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              hold_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              step_o
);
  logic [RATE_W-1:0] cnt_q;

  assign step_o = !clr_i && !hold_i && (cnt_q >= rate_i);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (hold_i) cnt_q <= cnt_q;
    else if (step_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R5: the count does not move while held
  a_r5_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && !clr_i) |=> $stable(cnt_q));
  // R6: a clear restarts the interval
  a_r6_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/chirp_freq_acc.sv
module chirp_freq_acc #(
  parameter int FREQ_W = chirp_pkg::FREQ_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              step_i,
  input  logic [FREQ_W-1:0] delta_i,
  input  logic [FREQ_W-1:0] start_i,
  output logic [FREQ_W-1:0] freq_o
);
  logic [FREQ_W-1:0] sum_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      sum_q <= '0;
    else if (clr_i)  sum_q <= '0;
    else if (step_i) sum_q <= sum_q + delta_i;
  end

  assign freq_o = start_i + sum_q;

  // R6: clear returns the sum to zero
  a_r6_sum_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (sum_q == '0));
  // R2: without a step or clear the sum keeps its value
  a_r2_sum_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !step_i) |=> $stable(sum_q));
  // R4: a step moves the sum by the signed delta
  a_r4_signed_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && step_i) |=> ((sum_q - $past(sum_q)) == $past(delta_i)));
endmodule

// File: rtl/chirp_phase_acc.sv
module chirp_phase_acc #(
  parameter int FREQ_W = chirp_pkg::FREQ_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic [FREQ_W-1:0] freq_i,
  output logic [FREQ_W-1:0] phase_o
);
  logic [FREQ_W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     phase_q <= '0;
    else if (clr_i) phase_q <= '0;
    else            phase_q <= phase_q + freq_i;
  end

  assign phase_o = phase_q;

  // R7: phase clear silences the output
  a_r7_phase_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (phase_q == '0));
  // R8: the phase advances by the frequency every clock
  a_r8_phase_adv: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((phase_q - $past(phase_q)) == $past(freq_i)));
endmodule

// File: rtl/chirp_update_timer.sv
module chirp_update_timer #(
  parameter int UPD_W = chirp_pkg::UPD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [UPD_W-1:0] period_i,
  output logic             tick_o
);
  logic [UPD_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q >= period_i);

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!en_i || tick_o)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  // R9: a disabled timer never fires
  a_r9_no_tick_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> !tick_o);
  // R9: each tick restarts the interval
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (cnt_q == '0));
endmodule

// File: rtl/chirp_sweep_engine.sv
module chirp_sweep_engine
  import chirp_pkg::*;
#(
  parameter int FW = FREQ_W,
  parameter int RW = RATE_W,
  parameter int UW = UPD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] start_freq_i,
  input  logic [FW-1:0] delta_i,
  input  logic [RW-1:0] ramp_rate_i,
  input  logic [UW-1:0] upd_period_i,
  input  logic          upd_en_i,
  input  logic          hold_i,
  input  logic          clr_freq_i,
  input  logic          clr_phase_i,
  output logic [FW-1:0] freq_o,
  output logic [FW-1:0] phase_o
);
  logic auto_tick;
  logic clr_any;
  logic step;

  chirp_update_timer #(.UPD_W(UW)) u_upd (
    .clk(clk), .rst_n(rst_n), .en_i(upd_en_i),
    .period_i(upd_period_i), .tick_o(auto_tick)
  );

  assign clr_any = clr_freq_i | auto_tick;

  chirp_ramp_timer #(.RATE_W(RW)) u_ramp (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_any), .hold_i(hold_i),
    .rate_i(ramp_rate_i), .step_o(step)
  );

  chirp_freq_acc #(.FREQ_W(FW)) u_facc (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_any), .step_i(step),
    .delta_i(delta_i), .start_i(start_freq_i), .freq_o(freq_o)
  );

  chirp_phase_acc #(.FREQ_W(FW)) u_pacc (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_phase_i),
    .freq_i(freq_o), .phase_o(phase_o)
  );

  // R5: hold without clear keeps the frequency constant
  a_r5_hold_freq: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && !clr_any && $stable(start_freq_i)) |=> $stable(freq_o) || $changed(start_freq_i));
  // R6: a manual clear brings the start frequency back
  a_r6_back_to_start: assert property (@(posedge clk) disable iff (!rst_n)
    clr_freq_i |=> (freq_o == start_freq_i));
endmodule

// File: tb/chirp_sweep_engine_tb.sv
module chirp_sweep_engine_tb;
  localparam int FW = 48;
  localparam int RW = 20;
  localparam int UW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [FW-1:0] start_freq = '0;
  logic [FW-1:0] delta = '0;
  logic [RW-1:0] rate = '0;
  logic [UW-1:0] period = '0;
  logic          upd_en = 1'b0;
  logic          hold = 1'b0;
  logic          clr_f = 1'b0;
  logic          clr_p = 1'b0;
  logic [FW-1:0] freq;
  logic [FW-1:0] phase;

  int errs = 0;
  int checks = 0;
  string tag = "R1";
  bit done = 1'b0;

  always #2 clk = ~clk;

  chirp_sweep_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start_freq_i(start_freq), .delta_i(delta),
    .ramp_rate_i(rate), .upd_period_i(period), .upd_en_i(upd_en),
    .hold_i(hold), .clr_freq_i(clr_f), .clr_phase_i(clr_p),
    .freq_o(freq), .phase_o(phase)
  );

  // reference model built from the requirements
  logic [FW-1:0] m_sum = '0;
  logic [FW-1:0] m_ph = '0;
  logic [RW-1:0] m_rc = '0;
  logic [UW-1:0] m_tc = '0;

  function automatic logic [FW-1:0] exp_freq();
    return start_freq + m_sum;
  endfunction

  always @(posedge clk) begin
    logic tick;
    logic [FW-1:0] f_now;
    if (!rst_n) begin
      m_sum = '0; m_ph = '0; m_rc = '0; m_tc = '0;
    end else begin
      f_now = exp_freq();
      tick = upd_en && (m_tc >= period);
      m_tc = (!upd_en || tick) ? '0 : m_tc + 1'b1;
      m_ph = clr_p ? '0 : m_ph + f_now;
      if (clr_f || tick) begin
        m_sum = '0; m_rc = '0;
      end else if (!hold) begin
        if (m_rc >= rate) begin m_sum = m_sum + delta; m_rc = '0; end
        else m_rc = m_rc + 1'b1;
      end
    end
  end

  task automatic chk(input string t, input logic [FW-1:0] act, input logic [FW-1:0] expv);
    checks++;
    if (act !== expv) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", t, act, expv);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk({tag, " freq"}, freq, exp_freq());
      chk({tag, " phase"}, phase, m_ph);
    end
  endtask

  task automatic clear_all();
    clr_f = 1'b1; clr_p = 1'b1; hold = 1'b0; upd_en = 1'b0;
    cyc(1);
    clr_f = 1'b0; clr_p = 1'b0;
  endtask

  initial begin
    logic [FW-1:0] held;
    void'($urandom(32'd4242));
    start_freq = 48'h0000_1000_0000;
    repeat (3) @(negedge clk);
    tag = "R1";
    chk("R1 reset freq", freq, start_freq);
    chk("R1 reset phase", phase, '0);
    rst_n = 1'b1;
    chk("R1 released freq", freq, start_freq);

    // R3: step every clock, then every 4 clocks
    tag = "R3"; delta = 48'd5; rate = '0;
    cyc(10);
    chk("R3 rate0 ten steps", freq, start_freq + 48'd50);
    clear_all();
    rate = 20'd3;
    cyc(3);
    chk("R3 no step before N+1", freq, start_freq);
    cyc(1);
    chk("R3 step at N+1", freq, start_freq + 48'd5);
    cyc(12);
    rate = 20'd100; cyc(5); rate = 20'd1; cyc(6);

    // R4: negative delta sweeps down
    tag = "R4"; clear_all();
    delta = 48'hFFFF_FFFF_FFF9; rate = 20'd1;
    cyc(8);
    chk("R4 down sweep", freq, start_freq - 48'd28);

    // R2: start change visible immediately
    tag = "R2";
    start_freq = 48'h0000_2000_0000;
    #0;
    chk("R2 start follows", freq, exp_freq());
    cyc(5);

    // R5: hold freezes frequency, phase still moves
    tag = "R5"; rate = '0; delta = 48'd3;
    hold = 1'b1; cyc(1); held = freq;
    cyc(10);
    chk("R5 held freq", freq, held);
    hold = 1'b0; cyc(4);

    // R6: clear overrides hold
    tag = "R6"; hold = 1'b1; clr_f = 1'b1;
    cyc(1);
    chk("R6 clear over hold", freq, start_freq);
    clr_f = 1'b0; hold = 1'b0; rate = 20'd2; cyc(9);

    // R7: phase clear
    tag = "R7"; clr_p = 1'b1; cyc(5);
    chk("R7 phase zero", phase, '0);
    clr_p = 1'b0; cyc(3);

    // R8: phase wrap
    tag = "R8"; clear_all();
    start_freq = 48'hC000_0000_0001; delta = '0; cyc(6);

    // R10: frequency wraps without a stop point
    tag = "R10"; clear_all();
    start_freq = 48'hFFFF_FFFF_FFF0; delta = 48'd7; rate = '0;
    cyc(4);
    chk("R10 wrap", freq, 48'h0000_0000_000C);

    // R9: automatic sawtooth
    tag = "R9"; clear_all();
    start_freq = 48'h0000_0100_0000; delta = 48'd11; rate = 20'd1;
    period = 32'd9; upd_en = 1'b1;
    cyc(10);
    chk("R9 reset at P+1", freq, start_freq);
    cyc(45);
    upd_en = 1'b0; cyc(30);

    // mixed random stimulus
    tag = "R2";
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 50) == 0) start_freq = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
      if (($urandom % 40) == 0) delta = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
      if (($urandom % 60) == 0) rate = $urandom % 6;
      if (($urandom % 200) == 0) begin period = $urandom % 40; upd_en = $urandom; end
      hold  = (($urandom % 8) == 0);
      clr_f = (($urandom % 64) == 0);
      clr_p = (($urandom % 64) == 0);
      cyc(1);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule